// File: doc/BRIEF.md
# Solo-Controlled Mono Headphone Mixer

This block folds a sixteen-channel time-multiplexed audio stream into one mono sample per frame for a headphone converter. Samples arrive one per cycle with a channel index. A strobe travels with the channel-0 sample and marks where each frame begins. A controller supplies a sixteen-bit solo mask, one bit per channel. The mask decides which channels reach the mix and how far the sum is scaled down.

With the mask empty, every channel is summed and the total is divided by sixteen. With a single bit set, that channel passes through at unity gain. With several bits set, only those channels are summed, and the sum is divided by the smallest power of two that is not below the number of soloed channels, so a legal frame cannot clip. A mask change is sampled only on the frame strobe, so one frame is never mixed under two gain settings. The result is held in a register, saturated to the sample width, and announced with a one-cycle valid pulse.

Top module: `hp_solo_mixer`

## Requirements
- R1: After a valid sample whose channel index is 15 is taken at a clock edge, `mix_valid_o` is high for exactly the following cycle, and it is low in every other cycle.
- R2: With an all-zero mask in force, the output is the signed sum of every valid sample of the frame, arithmetically shifted right by 4 (floor division by 16).
- R3: With exactly one mask bit set (bit i selects channel i), the output is the sum of that channel's samples, unshifted.
- R4: With N ≥ 2 mask bits set, the output is the sum of the selected channels' samples, arithmetically shifted right by ceil(log2 N).
- R5: When the mask in force is non-zero, samples on channels whose mask bit is clear have no effect on the output.
- R6: The mask is sampled only on a valid sample that carries the frame strobe, and that sample already uses it. A mask change at any other time takes effect at the next frame start.
- R7: The shifted result is saturated to the signed 24-bit range [-8388608, 8388607]. This can happen only when a frame repeats a channel index.
- R8: During reset the output is 0, `mix_valid_o` is low, and the mask in force is all-zero until the first frame strobe.
- R9: `mix_data_o` keeps its last value in every cycle without a valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| solo_mask_i | input | 16 | Solo selection, bit i for channel i |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_frame_i | input | 1 | Frame start, asserted with the channel-0 sample |
| smp_chan_i | input | 4 | Channel index of the sample |
| smp_data_i | input | 24 | Signed sample |
| mix_valid_o | output | 1 | One-cycle pulse marking a new mono sample |
| mix_data_o | output | 24 | Signed saturated mono sample |

## Verification
A wrong accumulator or a wrong held mask does not show up until the channel-15 sample closes the frame. The error then appears as a wrong `mix_data_o` value in the cycle of the valid pulse. A wrong shift count shows up the same way, as a result off by a power of two. A mask latched at the wrong moment affects the first frame after a mid-frame change, or the frame in which it changed. The bench makes a change in both places. The valid pulse and the held output value can be checked in every cycle.

// File: rtl/hpmix_pkg.sv
// Shared sizing helpers for the headphone mixer.
// Assumes: channel counts are at least 2.
package hpmix_pkg;

    // Width needed to count 0..n inclusive.
    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/hpmix_gain_ctrl.sv
// Holds the solo mask in force and the right-shift that goes with it.
// Assumes: a new mask is taken only with a valid frame-start sample, and the
// sample that carries the strobe already sees the new setting.
module hpmix_gain_ctrl
    import hpmix_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int SHIFT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [NUM_CH-1:0] solo_mask_i,
    output logic [NUM_CH-1:0] eff_mask,
    output logic [SHIFT_W-1:0] eff_shift
);
    localparam int CNT_W      = count_width(NUM_CH);
    localparam int FULL_SHIFT = $clog2(NUM_CH);

    logic [NUM_CH-1:0]  mask_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [CNT_W-1:0]   sel_cnt;
    logic [SHIFT_W-1:0] new_shift;

    // Count soloed channels in the incoming mask.
    always_comb begin
        sel_cnt = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            sel_cnt = sel_cnt + CNT_W'(solo_mask_i[i]);
        end
    end

    // Shift: full for no solo, else ceil(log2(count)).
    always_comb begin
        if (sel_cnt == '0) begin
            new_shift = SHIFT_W'(FULL_SHIFT);
        end else begin
            new_shift = '0;
            for (int i = 0; i < FULL_SHIFT; i++) begin
                if ((CNT_W'(1) << i) < sel_cnt) begin
                    new_shift = SHIFT_W'(i + 1);
                end
            end
        end
    end

    // Latch the setting at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            shift_q <= SHIFT_W'(FULL_SHIFT);
        end else if (frame_start) begin
            mask_q  <= solo_mask_i;
            shift_q <= new_shift;
        end
    end

    // The strobe sample uses the fresh setting, all others the held one.
    always_comb begin
        eff_mask  = frame_start ? solo_mask_i : mask_q;
        eff_shift = frame_start ? new_shift   : shift_q;
    end

endmodule

// File: rtl/hpmix_accum.sv
// Frame accumulator: adds each enabled sample into a wide signed sum.
// Assumes: the frame strobe restarts the sum with its own sample, and the
// channel index NUM_CH-1 closes the frame.
module hpmix_accum #(
    parameter int NUM_CH   = 16,
    parameter int CH_W     = 4,
    parameter int SAMPLE_W = 24,
    parameter int ACC_W    = 28
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic                    frame_start,
    input  logic [CH_W-1:0]         chan,
    input  logic [SAMPLE_W-1:0]     data,
    input  logic [NUM_CH-1:0]       eff_mask,
    output logic signed [ACC_W-1:0] frame_sum,
    output logic                    frame_done
);
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] term;
    logic signed [ACC_W-1:0] base;
    logic                    chan_en;

    // Channel enabled when no solo is active or its bit is set.
    always_comb begin
        chan_en = (eff_mask == '0) || eff_mask[chan];
        term    = chan_en ? {{(ACC_W-SAMPLE_W){data[SAMPLE_W-1]}}, data} : '0;
        base    = frame_start ? '0 : acc_q;
    end

    // Running total including the current sample.
    always_comb begin
        frame_sum  = base + term;
        frame_done = smp_valid && (chan == CH_W'(NUM_CH - 1));
    end

    // Keep the running total.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (smp_valid) begin
            acc_q <= frame_sum;
        end
    end

endmodule

// File: rtl/hpmix_out_stage.sv
// Scales the finished frame sum, saturates it and registers the mono sample.
// Assumes: frame_done is a single-cycle qualifier for frame_sum.
module hpmix_out_stage #(
    parameter int ACC_W    = 28,
    parameter int SAMPLE_W = 24,
    parameter int SHIFT_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_done,
    input  logic signed [ACC_W-1:0] frame_sum,
    input  logic [SHIFT_W-1:0]      shift,
    output logic                    mix_valid,
    output logic [SAMPLE_W-1:0]     mix_data
);
    localparam logic signed [ACC_W-1:0] SAT_MAX =
        {{(ACC_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] SAT_MIN =
        {{(ACC_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

    logic signed [ACC_W-1:0] scaled;
    logic [SAMPLE_W-1:0]     clipped;

    // Arithmetic shift then clamp to the sample range.
    always_comb begin
        scaled = frame_sum >>> shift;
        if (scaled > SAT_MAX) begin
            clipped = SAT_MAX[SAMPLE_W-1:0];
        end else if (scaled < SAT_MIN) begin
            clipped = SAT_MIN[SAMPLE_W-1:0];
        end else begin
            clipped = scaled[SAMPLE_W-1:0];
        end
    end

    // Register the result and pulse valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mix_valid <= 1'b0;
            mix_data  <= '0;
        end else begin
            mix_valid <= frame_done;
            if (frame_done) begin
                mix_data <= clipped;
            end
        end
    end

endmodule

// File: rtl/hp_solo_mixer.sv
// Mono headphone mixer with solo-dependent gain.
// Assumes: one TDM sample per valid cycle, the frame strobe comes with
// channel 0, and the channel NUM_CH-1 sample ends each frame.
module hp_solo_mixer #(
    parameter int NUM_CH   = 16,
    parameter int SAMPLE_W = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          solo_mask_i,
    input  logic                       smp_valid_i,
    input  logic                       smp_frame_i,
    input  logic [$clog2(NUM_CH)-1:0]  smp_chan_i,
    input  logic [SAMPLE_W-1:0]        smp_data_i,
    output logic                       mix_valid_o,
    output logic [SAMPLE_W-1:0]        mix_data_o
);
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int ACC_W   = SAMPLE_W + CH_W;
    localparam int SHIFT_W = $clog2(CH_W + 1);

    logic                    frame_start;
    logic [NUM_CH-1:0]       eff_mask;
    logic [SHIFT_W-1:0]      eff_shift;
    logic signed [ACC_W-1:0] frame_sum;
    logic                    frame_done;

    // A frame starts only on a valid strobed sample.
    assign frame_start = smp_valid_i && smp_frame_i;

    hpmix_gain_ctrl #(
        .NUM_CH  (NUM_CH),
        .SHIFT_W (SHIFT_W)
    ) u_gain (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .solo_mask_i (solo_mask_i),
        .eff_mask    (eff_mask),
        .eff_shift   (eff_shift)
    );

    hpmix_accum #(
        .NUM_CH   (NUM_CH),
        .CH_W     (CH_W),
        .SAMPLE_W (SAMPLE_W),
        .ACC_W    (ACC_W)
    ) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid   (smp_valid_i),
        .frame_start (frame_start),
        .chan        (smp_chan_i),
        .data        (smp_data_i),
        .eff_mask    (eff_mask),
        .frame_sum   (frame_sum),
        .frame_done  (frame_done)
    );

    hpmix_out_stage #(
        .ACC_W    (ACC_W),
        .SAMPLE_W (SAMPLE_W),
        .SHIFT_W  (SHIFT_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_sum  (frame_sum),
        .shift      (eff_shift),
        .mix_valid  (mix_valid_o),
        .mix_data   (mix_data_o)
    );

endmodule

// File: rtl/hpmix_checker.sv
// Temporal checks on the mixer ports and on the held mask and sum.
// Assumes: bound into hp_solo_mixer, and the internal names match.
module hpmix_checker #(
    parameter int NUM_CH   = 16,
    parameter int SAMPLE_W = 24,
    parameter int ACC_W    = 28
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      smp_valid_i,
    input logic                      smp_frame_i,
    input logic [$clog2(NUM_CH)-1:0] smp_chan_i,
    input logic                      mix_valid_o,
    input logic [SAMPLE_W-1:0]       mix_data_o,
    input logic [NUM_CH-1:0]         mask_q,
    input logic [ACC_W-1:0]          acc_q
);
    localparam logic [$clog2(NUM_CH)-1:0] LAST = $clog2(NUM_CH)'(NUM_CH - 1);

    // R1: the last channel sample is followed by a valid pulse
    a_r1_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && smp_chan_i == LAST) |=> mix_valid_o);

    // R1: no valid pulse without a last-channel sample
    a_r1_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_valid_i && smp_chan_i == LAST) |=> !mix_valid_o);

    // R9: output held while no pulse
    a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !mix_valid_o |-> $stable(mix_data_o));

    // R6: held mask changes only on a frame start
    a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_valid_i && smp_frame_i) |=> $stable(mask_q));

    // R5: a masked-out sample leaves the sum untouched
    a_r5_masked_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && !smp_frame_i && mask_q != '0 && !mask_q[smp_chan_i])
            |=> $stable(acc_q));

endmodule

bind hp_solo_mixer hpmix_checker #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W),
    .ACC_W    (ACC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid_i (smp_valid_i),
    .smp_frame_i (smp_frame_i),
    .smp_chan_i  (smp_chan_i),
    .mix_valid_o (mix_valid_o),
    .mix_data_o  (mix_data_o),
    .mask_q      (u_gain.mask_q),
    .acc_q       (u_acc.acc_q)
);

// File: tb/tb_hp_solo_mixer.sv
// Bench: a behavioural reference updated on each rising edge and compared
// with the DUT on every falling edge.
module tb_hp_solo_mixer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] solo_mask_i = '0;
    logic        smp_valid_i = 1'b0;
    logic        smp_frame_i = 1'b0;
    logic [3:0]  smp_chan_i = '0;
    logic [23:0] smp_data_i = '0;
    logic        mix_valid_o;
    logic [23:0] mix_data_o;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    started = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R8";

    // reference state
    int          ref_mask = 0;
    int          ref_sum = 0;
    bit          exp_valid = 1'b0;
    int          exp_data = 0;

    always #2 clk = ~clk;   // 250 MHz

    hp_solo_mixer dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .solo_mask_i (solo_mask_i),
        .smp_valid_i (smp_valid_i),
        .smp_frame_i (smp_frame_i),
        .smp_chan_i  (smp_chan_i),
        .smp_data_i  (smp_data_i),
        .mix_valid_o (mix_valid_o),
        .mix_data_o  (mix_data_o)
    );

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            started   = 1'b1;
            ref_mask  = 0;
            ref_sum   = 0;
            exp_valid = 1'b0;
            exp_data  = 0;
        end else begin
            exp_valid = 1'b0;
            if (smp_valid_i) begin
                int ch;
                ch = int'(smp_chan_i);
                if (smp_frame_i) begin
                    ref_mask = int'(solo_mask_i);
                    ref_sum  = 0;
                end
                if (ref_mask == 0 || ((ref_mask >> ch) & 1) == 1)
                    ref_sum += int'($signed(smp_data_i));
                if (ch == 15) begin
                    int n, sh, r;
                    n = 0;
                    for (int b = 0; b < 16; b++) n += (ref_mask >> b) & 1;
                    sh = 0;
                    if (n == 0) sh = 4;
                    else while ((1 << sh) < n) sh++;
                    r = ref_sum >>> sh;
                    if (r > 8388607) r = 8388607;
                    if (r < -8388608) r = -8388608;
                    exp_valid = 1'b1;
                    exp_data  = r;
                end
            end
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            n_checks++;
            if (mix_valid_o !== exp_valid || int'($signed(mix_data_o)) != exp_data
                || $isunknown(mix_data_o)) begin
                n_fail++;
                $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d",
                         cur_req, mix_valid_o, $signed(mix_data_o), exp_valid, exp_data);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below 50000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic put(input int ch, input bit frm, input int d);
        @(negedge clk);
        smp_valid_i = 1'b1;
        smp_frame_i = frm;
        smp_chan_i  = ch[3:0];
        smp_data_i  = d[23:0];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid_i = 1'b0;
            smp_frame_i = 1'b0;
            smp_data_i  = 24'h5A5A5A;
        end
    endtask

    task automatic frame(input int base, input int step);
        for (int c = 0; c < 16; c++) put(c, c == 0, base + c * step);
        idle(3);
    endtask

    initial begin
        idle(4);                       // R8: reset values checked each cycle
        rst_n = 1'b1;
        idle(2);

        cur_req = "R2";                // no solo: divide by 16, floor
        frame(1000, 37);
        frame(-500001, 3);
        frame(8388607, 0);
        frame(-8388608, 0);

        cur_req = "R3";                // single solo, unity
        solo_mask_i = 16'h0020;
        frame(7000, 1111);
        solo_mask_i = 16'h8000;
        frame(-8388608, 1);

        cur_req = "R4";                // several solos
        solo_mask_i = 16'h0003;
        frame(8388607, 0);
        solo_mask_i = 16'h0111;
        frame(-77777, 5003);
        solo_mask_i = 16'h0F01;
        frame(123457, -999);
        solo_mask_i = 16'hFFFF;
        frame(-8388608, 0);

        cur_req = "R5";                // unselected channels carry extremes
        solo_mask_i = 16'h0410;
        for (int c = 0; c < 16; c++)
            put(c, c == 0, (c == 4 || c == 10) ? 3001 * c : ((c & 1) ? 8388607 : -8388608));
        idle(2);

        cur_req = "R6";                // mid-frame mask change waits for next frame
        solo_mask_i = 16'h0001;
        for (int c = 0; c < 8; c++) put(c, c == 0, 4000 + c);
        solo_mask_i = 16'h0002;
        for (int c = 8; c < 16; c++) put(c, 1'b0, 4000 + c);
        idle(1);
        frame(250, 250);

        cur_req = "R7";                // repeated channel drives saturation
        solo_mask_i = 16'h0001;
        put(0, 1'b1, 8388607);
        for (int i = 0; i < 14; i++) put(0, 1'b0, 8388607);
        put(15, 1'b0, 1);
        idle(2);
        put(0, 1'b1, -8388608);
        for (int i = 0; i < 14; i++) put(0, 1'b0, -8388608);
        put(15, 1'b0, 1);
        idle(2);

        cur_req = "R9";                // gaps inside a frame, long idle after
        solo_mask_i = 16'h0000;
        for (int c = 0; c < 16; c++) begin
            put(c, c == 0, 64 * c - 300);
            idle(c % 3);
        end
        idle(10);

        cur_req = "R1";                // back-to-back frames
        frame(11, 13);
        for (int c = 0; c < 16; c++) put(c, c == 0, -c * 1000);
        for (int c = 0; c < 16; c++) put(c, c == 0, c * 1000);
        idle(3);

        cur_req = "R8";                // reset in mid-frame clears state
        for (int c = 0; c < 6; c++) put(c, c == 0, 99999);
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid_i = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        for (int c = 6; c < 16; c++) put(c, 1'b0, 16);
        idle(3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule